// File: doc/BRIEF.md
# SPI Burst Exchange Engine

This block is the shifting core of an SPI master. It takes 32-bit words from an external transmit FIFO and sends them out on MOSI as bursts. The burst bit count comes from a programmable length field, and a single burst may cover several FIFO words. The bits that arrive on MISO are built into 32-bit words and pushed into an external receive FIFO. When the receive FIFO has no room, the word is dropped and a sticky overflow flag is raised.

A transfer starts in one of two ways. In immediate mode it starts whenever transmit data is waiting. In requested mode it starts on a rising edge of an exchange request input. For the selected channel, when that channel is configured as master, the block drives its active-low chip select. A per-channel multi-burst control decides what happens when a burst ends. In multi-burst mode, bursts follow one another until the transmit FIFO is empty. Otherwise the block stops after each burst and raises a sticky done flag.

Top module: `spi_burst_xchg`

## Requirements
- R1: While `enable` is high and `masterMode[chanSel]` is 1, `csN[chanSel]` is 0 and every other `csN` bit is 1. In all other cases every `csN` bit is 1.
- R2: When `immStart` is 1, an enabled master starts fetching as soon as `txEmpty` is low, and it keeps restarting for as long as words are queued. No exchange request is needed.
- R3: When `immStart` is 0, only a 0-to-1 change of `xchgReq` seen while idle starts an exchange. If the transmit FIFO is empty at that moment, `xferDone` is set on the next edge and nothing is shifted.
- R4: Each fetched word sends min(remaining burst bits, 32) bits, rounded up to whole bytes. Byte 0 (bits 7:0) goes first, then byte 1, and so on. A received byte lands at the same byte position of `rxData`, and bytes that were not shifted read as zero.
- R5: A burst begins with its remaining-bit count loaded from `burstLen`+1, and that count is carried across words. Multi-burst mode is active when the channel is master, `immStart` is 0 and `ssMulti[chanSel]` is 1. In multi-burst mode, `xchgHeld` is raised when a burst begins.
- R6: When a burst ends outside multi-burst mode, `xferDone` is set and the engine goes idle, even if words are still queued.
- R7: When a word completes while `rxFull` is 1, the word is not pushed and `rxOvf` is set. If a set and a `clrOvf` fall in the same cycle, the set wins.
- R8: When a word completes and the transmit FIFO is empty, `xferDone` is set, `xchgHeld` is cleared and the engine goes idle.
- R9: `sclk` idles low, and each half period lasts `clkDiv`+1 clock cycles. Within a byte, MOSI presents bit 7 first, and MISO is sampled on each rising `sclk` edge.
- R10: `busy` is high from fetch to store. An exchange request edge that arrives while `busy` is high is ignored.
- R11: While `enable` is low, no transfer starts. `xferDone`, `rxOvf`, `xchgHeld` and the burst count are cleared, and all `csN` bits are high.
- R12: `xferDone` and `rxOvf` stay set until `clrDone` or `clrOvf` respectively is high at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low acts as a soft reset |
| chanSel | input | $clog2(NCH) | Selected channel |
| masterMode | input | NCH | Per-channel master mode |
| immStart | input | 1 | 1: immediate start, 0: start on exchange request |
| xchgReq | input | 1 | Exchange request level; its rising edge starts a transfer |
| ssMulti | input | NCH | Per-channel multi-burst control |
| burstLen | input | LENW | Burst length in bits minus one |
| clkDiv | input | DIVW | SCLK half period minus one, in clock cycles |
| txEmpty | input | 1 | Transmit FIFO empty |
| txData | input | 32 | Transmit FIFO head word |
| txPop | output | 1 | Transmit FIFO pop |
| rxFull | input | 1 | Receive FIFO full |
| rxPush | output | 1 | Receive FIFO push |
| rxData | output | 32 | Received word |
| clrDone | input | 1 | Clears xferDone |
| clrOvf | input | 1 | Clears rxOvf |
| miso | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| csN | output | NCH | Active-low chip selects |
| busy | output | 1 | Word transfer in progress |
| xchgHeld | output | 1 | Exchange held in multi-burst mode |
| xferDone | output | 1 | Sticky transfer-complete flag |
| rxOvf | output | 1 | Sticky receive-overflow flag |

## Verification
Two events can land in the same cycle: setting the overflow flag when a completed word meets a full receive FIFO, and clearing that flag through `clrOvf`. The bench holds `clrOvf` high for the whole of a transfer into a full FIFO. On the cycle after the store it expects `rxOvf` at 1, because the set wins. One cycle later it expects 0. The same bench also raises a second exchange-request edge in the middle of a word, and then checks that after the burst ends the engine stays idle with the leftover words still queued.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_SHIFT = 2'd2,
    ST_STORE = 2'd3
  } engState_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic       load;    // latch a new TX word, clear RX word
    logic       sample;  // capture miso at bitPos
    logic [4:0] bitPos;  // bit of the word on the wire
  } dpCmd_t;

endpackage

// File: rtl/spi_burst_ctrl.sv
module spi_burst_ctrl
  import spi_burst_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int CSW  = 2,
  parameter int LENW = 12,
  parameter int DIVW = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic [CSW-1:0]  chanSel,
  input  logic [NCH-1:0]  masterMode,
  input  logic            immStart,
  input  logic            xchgReq,
  input  logic [NCH-1:0]  ssMulti,
  input  logic [LENW-1:0] burstLen,
  input  logic [DIVW-1:0] clkDiv,
  input  logic            txEmpty,
  output logic            txPop,
  input  logic            rxFull,
  output logic            rxPush,
  input  logic            clrDone,
  input  logic            clrOvf,
  output logic            sclk,
  output logic [NCH-1:0]  csN,
  output logic            busy,
  output logic            xchgHeld,
  output logic            xferDone,
  output logic            rxOvf,
  output dpCmd_t          cmd
);

  localparam int RW = LENW + 1;

  engState_t       state;
  logic [RW-1:0]   remBits;
  logic [DIVW-1:0] divCnt;
  logic [2:0]      bitCnt;
  logic [1:0]      byteIdx;
  logic [1:0]      lastByte;
  logic            xchgPrev;

  logic            isMaster;
  logic            multiMode;
  logic            xchgRise;
  logic            goReq;
  logic [RW-1:0]   remStart;
  logic [RW-1:0]   remNext;
  logic [1:0]      lastByteCalc;
  logic            divTick;
  logic            burstOver;
  logic            doneSet;
  logic            ovfSet;

  // chip selects, one generated driver per channel
  for (genvar ch = 0; ch < NCH; ch++) begin : gCs
    assign csN[ch] = ~(enable & masterMode[chanSel] & (chanSel == CSW'(ch)));
  end

  always_comb begin
    isMaster  = masterMode[chanSel];
    multiMode = isMaster & ~immStart & ssMulti[chanSel];
    xchgRise  = xchgReq & ~xchgPrev;
    goReq     = enable & isMaster & (immStart ? ~txEmpty : xchgRise);
    remStart  = (remBits == '0) ? ({1'b0, burstLen} + RW'(1)) : remBits;
    remNext   = (remStart > RW'(32)) ? (remStart - RW'(32)) : '0;
    if (remStart > RW'(24))      lastByteCalc = 2'd3;
    else if (remStart > RW'(16)) lastByteCalc = 2'd2;
    else if (remStart > RW'(8))  lastByteCalc = 2'd1;
    else                         lastByteCalc = 2'd0;
    divTick   = (divCnt == clkDiv);
    burstOver = (remBits == '0) & ~multiMode;
    doneSet   = ((state == ST_IDLE) & goReq & txEmpty) |
                ((state == ST_STORE) & (burstOver | txEmpty));
    ovfSet    = (state == ST_STORE) & rxFull;
  end

  assign txPop      = (state == ST_FETCH);
  assign rxPush     = (state == ST_STORE) & ~rxFull;
  assign busy       = (state != ST_IDLE);
  assign cmd.load   = (state == ST_FETCH);
  assign cmd.sample = (state == ST_SHIFT) & divTick & ~sclk;
  assign cmd.bitPos = {byteIdx, ~bitCnt};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      remBits  <= '0;
      divCnt   <= '0;
      bitCnt   <= '0;
      byteIdx  <= '0;
      lastByte <= '0;
      sclk     <= 1'b0;
      xchgPrev <= 1'b0;
      xchgHeld <= 1'b0;
      xferDone <= 1'b0;
      rxOvf    <= 1'b0;
    end else begin
      xchgPrev <= xchgReq;
      if (!enable) begin
        state    <= ST_IDLE;
        remBits  <= '0;
        sclk     <= 1'b0;
        xchgHeld <= 1'b0;
        xferDone <= 1'b0;
        rxOvf    <= 1'b0;
      end else begin
        xferDone <= (xferDone & ~clrDone) | doneSet;
        rxOvf    <= (rxOvf & ~clrOvf) | ovfSet;
        unique case (state)
          ST_IDLE: begin
            if (goReq) begin
              if (txEmpty) xchgHeld <= 1'b0;
              else         state    <= ST_FETCH;
            end
          end
          ST_FETCH: begin
            remBits  <= remNext;
            lastByte <= lastByteCalc;
            if ((remBits == '0) && multiMode) xchgHeld <= 1'b1;
            bitCnt   <= '0;
            byteIdx  <= '0;
            divCnt   <= '0;
            sclk     <= 1'b0;
            state    <= ST_SHIFT;
          end
          ST_SHIFT: begin
            if (divTick) begin
              divCnt <= '0;
              sclk   <= ~sclk;
              if (sclk) begin
                if (bitCnt == 3'd7) begin
                  bitCnt <= '0;
                  if (byteIdx == lastByte) state   <= ST_STORE;
                  else                     byteIdx <= byteIdx + 2'd1;
                end else begin
                  bitCnt <= bitCnt + 3'd1;
                end
              end
            end else begin
              divCnt <= divCnt + DIVW'(1);
            end
          end
          ST_STORE: begin
            if (doneSet) begin
              state <= ST_IDLE;
              if (txEmpty) xchgHeld <= 1'b0;
            end else begin
              state <= ST_FETCH;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/spi_burst_dp.sv
module spi_burst_dp
  import spi_burst_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpCmd_t      cmd,
  input  logic [31:0] txData,
  input  logic        miso,
  output logic        mosi,
  output logic [31:0] rxData
);

  logic [31:0] txWord;
  logic [31:0] rxWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txWord <= '0;
      rxWord <= '0;
    end else if (cmd.load) begin
      txWord <= txData;
      rxWord <= '0;
    end else if (cmd.sample) begin
      rxWord[cmd.bitPos] <= miso;
    end
  end

  assign mosi   = txWord[cmd.bitPos];
  assign rxData = rxWord;

endmodule

// File: rtl/spi_burst_xchg.sv
module spi_burst_xchg
  import spi_burst_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int LENW = 12,
  parameter int DIVW = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    enable,
  input  logic [$clog2(NCH)-1:0]  chanSel,
  input  logic [NCH-1:0]          masterMode,
  input  logic                    immStart,
  input  logic                    xchgReq,
  input  logic [NCH-1:0]          ssMulti,
  input  logic [LENW-1:0]         burstLen,
  input  logic [DIVW-1:0]         clkDiv,
  input  logic                    txEmpty,
  input  logic [31:0]             txData,
  output logic                    txPop,
  input  logic                    rxFull,
  output logic                    rxPush,
  output logic [31:0]             rxData,
  input  logic                    clrDone,
  input  logic                    clrOvf,
  input  logic                    miso,
  output logic                    sclk,
  output logic                    mosi,
  output logic [NCH-1:0]          csN,
  output logic                    busy,
  output logic                    xchgHeld,
  output logic                    xferDone,
  output logic                    rxOvf
);

  localparam int CSW = $clog2(NCH);

  dpCmd_t cmd;

  spi_burst_ctrl #(
    .NCH(NCH), .CSW(CSW), .LENW(LENW), .DIVW(DIVW)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .chanSel(chanSel),
    .masterMode(masterMode), .immStart(immStart), .xchgReq(xchgReq),
    .ssMulti(ssMulti), .burstLen(burstLen), .clkDiv(clkDiv),
    .txEmpty(txEmpty), .txPop(txPop), .rxFull(rxFull), .rxPush(rxPush),
    .clrDone(clrDone), .clrOvf(clrOvf), .sclk(sclk), .csN(csN),
    .busy(busy), .xchgHeld(xchgHeld), .xferDone(xferDone), .rxOvf(rxOvf),
    .cmd(cmd)
  );

  spi_burst_dp uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .txData(txData),
    .miso(miso), .mosi(mosi), .rxData(rxData)
  );

endmodule

// File: rtl/spi_burst_xchg_chk.sv
module spi_burst_xchg_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rstN,
  input logic           enable,
  input logic [NCH-1:0] csN,
  input logic           txPop,
  input logic           txEmpty,
  input logic           rxPush,
  input logic           rxFull,
  input logic           rxOvf,
  input logic           busy,
  input logic           sclk,
  input logic           xchgHeld
);

  // R1: at most one chip select active
  a_r1_cs_single: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~csN) <= 1);

  // R11: disabled block releases every chip select
  a_r11_cs_released: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (&csN));

  // R7: a push only happens with room in the RX FIFO
  a_r7_push_room: assert property (@(posedge clk) disable iff (!rstN)
    rxPush |-> !rxFull);

  // R7: overflow only rises after a store met a full FIFO
  a_r7_ovf_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxOvf) |-> $past(rxFull));

  // R2: never pop an empty TX FIFO
  a_r2_pop_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    txPop |-> !txEmpty);

  // R9: sclk idles low outside a transfer
  a_r9_idle_sclk_low: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sclk);

  // R8: exchange hold drops only on empty TX or disable
  a_r8_held_drop: assert property (@(posedge clk) disable iff (!rstN)
    $fell(xchgHeld) |-> ($past(txEmpty) || !$past(enable)));

endmodule

bind spi_burst_xchg spi_burst_xchg_chk #(.NCH(NCH)) uChk (
  .clk(clk), .rstN(rstN), .enable(enable), .csN(csN), .txPop(txPop),
  .txEmpty(txEmpty), .rxPush(rxPush), .rxFull(rxFull), .rxOvf(rxOvf),
  .busy(busy), .sclk(sclk), .xchgHeld(xchgHeld)
);

// File: tb/tb_spi_burst_xchg.sv
module tb_spi_burst_xchg;

  localparam int NCH  = 4;
  localparam int LENW = 12;
  localparam int DIVW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [1:0] chanSel = '0;
  logic [NCH-1:0] masterMode = '0;
  logic immStart = 1'b0;
  logic xchgReq = 1'b0;
  logic [NCH-1:0] ssMulti = '0;
  logic [LENW-1:0] burstLen = '0;
  logic [DIVW-1:0] clkDiv = '0;
  logic txEmpty;
  logic [31:0] txData;
  logic txPop;
  logic rxFull = 1'b0;
  logic rxPush;
  logic [31:0] rxData;
  logic clrDone = 1'b0;
  logic clrOvf = 1'b0;
  logic miso;
  logic sclk, mosi, busy, xchgHeld, xferDone, rxOvf;
  logic [NCH-1:0] csN;

  always #10 clk = ~clk;

  spi_burst_xchg #(.NCH(NCH), .LENW(LENW), .DIVW(DIVW)) dut (.*);

  // slave returns the inverse of what it receives
  assign miso = ~mosi;

  // bench FIFOs and serial capture
  logic [31:0] txMem [0:7];
  int txCnt = 0, head = 0, rxCnt = 0, capCnt = 0, riseN = 0, cyc = 0;
  int rise0 = 0, rise1 = 0;
  logic [31:0] rxMem [0:15];
  logic capBits [0:1023];
  logic sclkPrev = 1'b0;
  logic fifoClr = 1'b0;

  assign txEmpty = (head >= txCnt);
  assign txData  = txMem[head[2:0]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    sclkPrev <= sclk;
    if (fifoClr) begin
      head <= 0; rxCnt <= 0; capCnt <= 0; riseN <= 0;
    end else begin
      if (txPop) head <= head + 1;
      if (rxPush && rxCnt < 16) begin
        rxMem[rxCnt] <= rxData;
        rxCnt <= rxCnt + 1;
      end
      if (sclk && !sclkPrev) begin
        if (capCnt < 1024) capBits[capCnt] <= mosi;
        capCnt <= capCnt + 1;
        if (riseN == 0) rise0 <= cyc;
        if (riseN == 1) rise1 <= cyc;
        riseN <= riseN + 1;
      end
    end
  end

  int nChecks = 0, nFails = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  initial begin : watchdog
    #3000000;
    nFails++;
    $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  task automatic clrFifos(input int words, input int seed);
    fifoClr = 1'b1;
    txCnt = words;
    for (int k = 0; k < 8; k++)
      txMem[k] = 32'hA5C3_0F96 ^ (k * 32'h0103_0507) ^ (seed * 32'h0001_1101);
    @(negedge clk);
    fifoClr = 1'b0;
  endtask

  task automatic softReset();
    enable = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
  endtask

  task automatic waitIdle();
    int quiet = 0;
    for (int t = 0; t < 20000 && quiet < 6; t++) begin
      @(negedge clk);
      quiet = busy ? 0 : quiet + 1;
    end
  endtask

  task automatic runCase(input int len, input int words, input bit multi,
                         input bit imm, input int div, input int sel);
    int rem, sent, nb, bitIdx, bitErr, rxErr;
    int nbArr [0:7];
    bit stop;
    logic [31:0] mask;
    enable = 1'b0;
    chanSel = 2'(sel);
    masterMode = 4'b1111;
    ssMulti = multi ? 4'(1 << sel) : ~4'(1 << sel);
    immStart = 1'b0;
    xchgReq = 1'b0;
    burstLen = LENW'(len);
    clkDiv = DIVW'(div);
    clrFifos(words, len);
    softReset();
    chk(csN == ~4'(1 << sel), "R1 chip select", 32'(csN), 32'(~4'(1 << sel)));
    if (imm) immStart = 1'b1; else xchgReq = 1'b1;
    for (int t = 0; t < 50 && !busy; t++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(xchgHeld == (multi && !imm), "R5 exchange hold", 32'(xchgHeld), 32'(multi && !imm));
    if (!imm) begin
      xchgReq = 1'b0;
      repeat (2) @(negedge clk);
      xchgReq = 1'b1;   // R10: edge while busy is ignored
    end
    waitIdle();
    xchgReq = 1'b0;
    immStart = 1'b0;
    // expected word split from the burst rules
    rem = 0; sent = 0; stop = 0;
    while (!stop && sent < words) begin
      if (rem == 0) rem = len + 1;
      nb = (rem >= 32) ? 4 : (rem + 7) / 8;
      rem = (rem > 32) ? rem - 32 : 0;
      nbArr[sent] = nb;
      sent++;
      if (rem == 0 && !multi && !imm) stop = 1;
    end
    chk(head == sent, "R6/R10 words fetched", 32'(head), 32'(sent));
    chk(rxCnt == sent, "R4 words received", 32'(rxCnt), 32'(sent));
    chk(xferDone == 1'b1, "R8 transfer done", 32'(xferDone), 32'd1);
    chk(xchgHeld == 1'b0, "R8 hold cleared", 32'(xchgHeld), 32'd0);
    bitIdx = 0; bitErr = 0; rxErr = 0;
    for (int k = 0; k < sent && k < rxCnt; k++) begin
      mask = '0;
      for (int b = 0; b < nbArr[k]; b++) begin
        mask[b*8 +: 8] = 8'hFF;
        for (int i = 7; i >= 0; i--) begin
          if (bitIdx < capCnt && capBits[bitIdx] !== txMem[k][b*8 + i]) bitErr++;
          bitIdx++;
        end
      end
      if (rxMem[k] !== (~txMem[k] & mask)) begin
        rxErr++;
        chk(1'b0, "R4 rx word", rxMem[k], ~txMem[k] & mask);
      end
    end
    chk(capCnt == bitIdx, "R9 sclk rising count", 32'(capCnt), 32'(bitIdx));
    chk(bitErr == 0, "R4/R9 mosi bit order", 32'(bitErr), 32'd0);
    chk(rxErr == 0, "R4 rx words match", 32'(rxErr), 32'd0);
    if (riseN >= 2)
      chk(rise1 - rise0 == 2 * (div + 1), "R9 sclk period", 32'(rise1 - rise0),
          32'(2 * (div + 1)));
  endtask

  initial begin : stim
    int lens [0:12] = '{0, 7, 8, 15, 23, 24, 31, 32, 33, 63, 64, 95, 127};
    repeat (3) @(negedge clk);
    chk(csN == '1, "R11 reset chip selects", 32'(csN), 32'hF);
    chk(!busy && !xferDone && !rxOvf && !sclk, "R11 reset flags",
        {busy, xferDone, rxOvf, sclk}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: chip select sweep over channels and master bits
    enable = 1'b1;
    for (int s = 0; s < NCH; s++) begin
      for (int m = 0; m < 16; m++) begin
        chanSel = 2'(s);
        masterMode = 4'(m);
        @(negedge clk);
        chk(csN == (m[s] ? ~4'(1 << s) : 4'hF), "R1 chip select sweep",
            32'(csN), 32'(m[s] ? ~4'(1 << s) : 4'hF));
      end
    end

    // R4 R5 R6 R9 R10: single-burst sweep over lengths
    foreach (lens[i]) runCase(lens[i], 3, 1'b0, 1'b0, i % 3, i % 4);
    // R5 R8: multi-burst
    runCase(15, 3, 1'b1, 1'b0, 0, 1);
    runCase(39, 4, 1'b1, 1'b0, 1, 2);
    // R2: immediate start
    runCase(7, 3, 1'b0, 1'b1, 0, 3);
    runCase(47, 4, 1'b0, 1'b1, 2, 0);

    // R12: done stays until cleared
    repeat (5) @(negedge clk);
    chk(xferDone == 1'b1, "R12 done sticky", 32'(xferDone), 32'd1);
    clrDone = 1'b1;
    @(negedge clk);
    clrDone = 1'b0;
    chk(xferDone == 1'b0, "R12 done cleared", 32'(xferDone), 32'd0);

    // R3: exchange request with empty TX FIFO
    clrFifos(0, 1);
    xchgReq = 1'b1;
    @(negedge clk);
    chk(xferDone == 1'b1 && !busy, "R3 empty exchange done",
        {busy, xferDone}, 32'd1);
    xchgReq = 1'b0;
    clrDone = 1'b1;
    @(negedge clk);
    clrDone = 1'b0;

    // R3: level without a new edge does nothing
    clrFifos(1, 2);
    repeat (20) @(negedge clk);
    chk(head == 0 && !busy, "R3 no edge no start", 32'(head), 32'd0);

    // R7: overflow with clear held high, set wins
    rxFull = 1'b1;
    clrOvf = 1'b1;
    burstLen = LENW'(7);
    xchgReq = 1'b1;
    for (int t = 0; t < 50 && !busy; t++) @(negedge clk);
    for (int t = 0; t < 500 && busy; t++) @(negedge clk);
    chk(rxOvf == 1'b1, "R7 overflow set beats clear", 32'(rxOvf), 32'd1);
    chk(rxCnt == 0, "R7 word discarded", 32'(rxCnt), 32'd0);
    @(negedge clk);
    chk(rxOvf == 1'b0, "R7 overflow cleared next", 32'(rxOvf), 32'd0);
    clrOvf = 1'b0;
    rxFull = 1'b0;
    xchgReq = 1'b0;

    // R11: disabled block ignores starts
    enable = 1'b0;
    clrFifos(2, 3);
    immStart = 1'b1;
    xchgReq = 1'b1;
    repeat (30) @(negedge clk);
    chk(head == 0 && !busy, "R11 disabled no transfer", 32'(head), 32'd0);
    chk(csN == '1 && !xferDone && !rxOvf, "R11 disabled outputs",
        {csN, xferDone, rxOvf}, 32'h3C);
    immStart = 1'b0;
    xchgReq = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule